// File: doc/BRIEF.md
# Ethernet Frame Check Sequence Receive Checker

This block sits in the receive path behind the byte-wide PHY adapter and decides whether each received frame arrived intact. It takes a stream of bytes framed by a start marker on the first byte and an end marker on the last byte. The last four bytes of every frame are the frame check sequence that the sender appended. Every byte, the check bytes included, runs through one CRC-32 shift register. The block never needs to know where the payload stops and the check field begins.

Each byte is bit-reversed so that its first-on-the-wire bit enters first. It is then folded into a 32-bit register in one clock using the generator polynomial 0x04C11DB7, the same update that the transmit-side generator uses. After the closing byte, an undamaged frame always leaves the constant 0xC704DD7B in the register. One clock after the end byte, the block raises a single-cycle result strobe with a pass/fail flag. Frames shorter than four bytes always fail. A new start marker in the middle of a frame silently abandons the old frame.

Top module: `eth_fcs_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `res_valid` and `res_ok` are low.
- R2: On the start-marked byte, the CRC register is preset to all ones, so bytes that came before it have no effect on the result.
- R3: A frame whose last four bytes are the correct check field yields `res_valid` high with `res_ok` high in the cycle after the end-marked byte is accepted. The check field is the complement of the CRC over the payload, sent lowest-order byte first, with bit 0 of each byte first on the wire.
- R4: A frame with any single bit inverted anywhere, check field included, yields `res_valid` high with `res_ok` low.
- R5: `res_valid` goes high exactly once for each accepted end-marked byte that closes an open frame, for one cycle only. `res_ok` is low whenever `res_valid` is low.
- R6: A frame of fewer than four bytes from start to end reports a failure. A four-byte frame of all zeros, which is the valid check field of an empty payload, passes.
- R7: A start-marked byte that arrives while a frame is open abandons that frame with no strobe and begins a new check.
- R8: Cycles with `in_valid` low do not change the check. End-marked bytes with no open frame and no start marker produce no strobe.
- R9: A byte that carries both start and end markers is a one-byte frame and reports a failure one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is present on `in_data` this cycle |
| in_data | input | 8 | Received byte, bit 0 first on the wire |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame (last check byte) |
| res_valid | output | 1 | One-cycle result strobe |
| res_ok | output | 1 | High with the strobe when the residue matched and the length was at least four |

## Verification
The only result is the strobe and its flag. It is due exactly one clock after the edge that accepts the end-marked byte, and nothing else is scheduled by this block. The bench drives each byte just after a falling edge and samples the outputs at the falling edge after the end byte, where the strobe must be high. It samples again one falling edge later, where the strobe must be low. The expected pass/fail value comes from a bench model that runs the CRC bit-serially in the mirrored (right-shifting) form and compares against the mirrored residue 0xDEBB20E3, so the model shares no structure with the byte-parallel RTL.

// File: rtl/fcs_chk_pkg.sv
package fcs_chk_pkg;

    localparam int unsigned CRC_W     = 32;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MIN_BYTES = 4;
    localparam int unsigned CNT_W     = $clog2(MIN_BYTES + 1);

    localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET  = {CRC_W{1'b1}};
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef struct packed {
        logic             open;
        logic [CRC_W-1:0] crc;
        logic [CNT_W-1:0] cnt;
        logic             res_valid;
        logic             res_ok;
    } chk_state_t;

endpackage

// File: rtl/fcs_byte_reflect.sv
module fcs_byte_reflect #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Wire-order swap: bit 0 (first on the wire) lands in the top position.
    for (genvar i = 0; i < WIDTH; i++) begin : g_swap
        assign dout[i] = din[WIDTH-1-i];
    end

endmodule

// File: rtl/fcs_crc_step.sv
module fcs_crc_step #(
    parameter int unsigned        CRC_W  = 32,
    parameter int unsigned        DATA_W = 8,
    parameter logic [CRC_W-1:0]   POLY   = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // Unrolled MSB-first LFSR: DATA_W shifts collapse into one XOR network.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int i = 0; i < DATA_W; i++) begin
            fb = c[CRC_W-1] ^ data_in[DATA_W-1-i];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = c;
    end

endmodule

// File: rtl/fcs_len_count.sv
module fcs_len_count #(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned CW    = $clog2(LIMIT + 1)
) (
    input  logic [CW-1:0] cur,
    input  logic          restart,
    output logic [CW-1:0] nxt,
    output logic          reached
);

    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] base;

    // Saturating byte count; the top value means "long enough".
    always_comb begin
        base    = restart ? '0 : cur;
        nxt     = (base == LIM) ? LIM : base + CW'(1);
        reached = (nxt == LIM);
    end

endmodule

// File: rtl/eth_fcs_checker.sv
module eth_fcs_checker
    import fcs_chk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              res_valid,
    output logic              res_ok
);

    chk_state_t state_d, state_q;

    logic [BYTE_W-1:0] data_wire_order;
    logic [CRC_W-1:0]  crc_base;
    logic [CRC_W-1:0]  crc_upd;
    logic [CNT_W-1:0]  cnt_upd;
    logic              len_ok;
    logic              take;
    logic              frame_open;

    fcs_byte_reflect #(.WIDTH(BYTE_W)) u_reflect (
        .din  (in_data),
        .dout (data_wire_order)
    );

    assign crc_base = in_sof ? CRC_PRESET : state_q.crc;

    fcs_crc_step #(.CRC_W(CRC_W), .DATA_W(BYTE_W), .POLY(CRC_POLY)) u_step (
        .crc_in  (crc_base),
        .data_in (data_wire_order),
        .crc_out (crc_upd)
    );

    fcs_len_count #(.LIMIT(MIN_BYTES), .CW(CNT_W)) u_len (
        .cur     (state_q.cnt),
        .restart (in_sof),
        .nxt     (cnt_upd),
        .reached (len_ok)
    );

    // A byte counts when it opens a frame or continues an open one.
    assign take = in_valid && (in_sof || state_q.open);

    always_comb begin
        state_d           = state_q;
        state_d.res_valid = 1'b0;
        state_d.res_ok    = 1'b0;
        if (take) begin
            state_d.crc = crc_upd;
            state_d.cnt = cnt_upd;
            if (in_eof) begin
                state_d.open      = 1'b0;
                state_d.res_valid = 1'b1;
                state_d.res_ok    = len_ok && (crc_upd == CRC_RESIDUE);
            end else begin
                state_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{open: 1'b0, crc: CRC_PRESET, cnt: '0,
                         res_valid: 1'b0, res_ok: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign frame_open = state_q.open;
    assign res_valid  = state_q.res_valid;
    assign res_ok     = state_q.res_ok;

endmodule

// File: rtl/fcs_chk_sva.sv
module fcs_chk_sva (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic in_eof,
    input logic frame_open,
    input logic res_valid,
    input logic res_ok
);

    // Independent byte count since the last start marker, saturating at 4.
    logic [2:0] seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     seen_q <= 3'd0;
        else if (in_valid && in_sof)    seen_q <= 3'd1;
        else if (in_valid && seen_q < 3'd4) seen_q <= seen_q + 3'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_ok));

    assert_strobe_follows_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && (in_sof || frame_open)) |=> res_valid);

    assert_strobe_has_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid && in_eof));

    assert_ok_only_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_ok |-> res_valid);

    assert_short_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && !in_sof && frame_open && seen_q < 3'd3) |=> !res_ok);

    assert_restart_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> !res_valid);

    assert_stray_end_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && !in_sof && !frame_open) |=> !res_valid);

    assert_one_byte_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && in_eof) |=> (res_valid && !res_ok));

endmodule

bind eth_fcs_checker fcs_chk_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .frame_open (frame_open),
    .res_valid  (res_valid),
    .res_ok     (res_ok)
);

// File: tb/eth_fcs_checker_tb.sv
module eth_fcs_checker_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       res_valid;
    logic       res_ok;

    int checks = 0;
    int errors = 0;

    logic [7:0] frm [0:127];

    always #5 clk = ~clk;

    eth_fcs_checker u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .res_valid(res_valid), .res_ok(res_ok)
    );

    // Mirrored bit-serial model: shift right, bit 0 of each byte first.
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ frm[i][b]) c = (c >> 1) ^ 32'hEDB8_8320;
                else                  c = c >> 1;
            end
        end
        return c;
    endfunction

    function automatic logic expect_ok(input int n);
        return (n >= 4) && (ref_crc(n) == 32'hDEBB_20E3);
    endfunction

    // Random payload of n-4 bytes followed by its check field.
    task automatic build_good(input int n);
        logic [31:0] f;
        for (int i = 0; i < n - 4; i++) frm[i] = 8'($urandom);
        f = ~ref_crc(n - 4);
        for (int k = 0; k < 4; k++) frm[n-4+k] = f[8*k +: 8];
    endtask

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {res_valid,res_ok} actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive a whole frame; optional idle gaps; check strobe and its end.
    task automatic send(input int n, input logic gaps, input string req);
        logic e;
        e = expect_ok(n);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1; in_data = frm[i];
            in_sof = (i == 0); in_eof = (i == n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        check(req, {res_valid, res_ok}, {1'b1, e});
        @(negedge clk);
        check("R5", {res_valid, res_ok}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, bitpos;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", {res_valid, res_ok}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {res_valid, res_ok}, 2'b00);

        // R6: empty payload + its check field (four zero bytes) passes.
        for (int i = 0; i < 4; i++) frm[i] = 8'h00;
        send(4, 1'b0, "R6");
        // R6: three bytes fail.
        frm[0] = 8'h12; frm[1] = 8'h34; frm[2] = 8'h56;
        send(3, 1'b0, "R6");
        // R9: single byte with both markers fails.
        frm[0] = 8'hFF;
        send(1, 1'b0, "R9");

        // R8: stray end byte with no open frame gives no strobe.
        in_valid = 1'b1; in_data = 8'hA5; in_eof = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_eof = 1'b0;
        check("R8", {res_valid, res_ok}, 2'b00);

        // R2: junk outside a frame, then a good frame still passes.
        for (int i = 0; i < 5; i++) begin
            in_valid = 1'b1; in_data = 8'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
        build_good(20);
        send(20, 1'b0, "R2");

        // R7: abandoned frame (no strobe), then a good frame passes.
        build_good(30);
        for (int i = 0; i < 10; i++) begin
            in_valid = 1'b1; in_data = frm[i]; in_sof = (i == 0); in_eof = 1'b0;
            @(negedge clk);
            if (i > 0) check("R7", {res_valid, res_ok}, 2'b00);
        end
        build_good(16);
        send(16, 1'b0, "R7");

        // R3 / R8: random good frames, some with idle gaps.
        for (int t = 0; t < 40; t++) begin
            n = 4 + int'($urandom % 61);
            build_good(n);
            send(n, t[0], t[0] ? "R8" : "R3");
        end

        // R4: one flipped bit anywhere, check field included.
        for (int t = 0; t < 40; t++) begin
            n = 4 + int'($urandom % 61);
            build_good(n);
            bitpos = int'($urandom % (8 * n));
            if (t == 0) bitpos = 8 * n - 1;
            frm[bitpos / 8][bitpos % 8] = ~frm[bitpos / 8][bitpos % 8];
            send(n, 1'b0, "R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule